// File: doc/BRIEF.md
# Valid-Bit Release Ring Consumer

This block is the hardware side of a small circular ring of buffer-release commands. Software fills ring slots in a shared command area, and this block consumes them in order. Each slot holds a command byte and a pool byte. The command byte carries three things: a presence flag, a command code and a buffer count. The block keeps a consumer index with an extra wrap bit. For every new slot it decodes the command byte and hands the buffer count and pool to a downstream buffer store, using a valid/ready handshake. Malformed slots are skipped and recorded in a sticky error flag.

The way the block detects a new slot depends on a production-mode input. In valid-bit mode there is no doorbell. A slot is new when its presence flag equals the expected polarity, and that polarity flips each time the index wraps. In the two index modes, software publishes a producer index instead, and the presence flag is ignored. Completed slots are counted, and an interrupt flag is raised when the count reaches a programmable threshold. The interrupt flag is cleared with a one-cycle write-one pulse.

Top module: `vbr_ring_consumer`

## Requirements
- R1: After reset, cons_idx is 4'b1000 (slot 0, wrap bit 1), and st_valid, irq and err_sticky are 0. All slots read back as zero.
- R2: In valid-bit mode (prod_mode = 2), the slot at cons_idx[2:0] is live when bit 7 of its command byte equals cons_idx[3]. For a well-formed live slot: st_valid is 1, st_count is bits 3:0, st_pool is the pool byte, and st_per_buf is 1 for code 3 and 0 for code 2. The code is bits 6:4 of the command byte.
- R3: In valid-bit mode, a slot whose bit 7 differs from cons_idx[3] is stale. It is not presented and not consumed.
- R4: cons_idx advances by exactly one on each cycle where st_valid and st_ready are both 1. While st_ready is 0, st_valid, st_count and st_pool hold steady.
- R5: When cons_idx moves from slot 7 to slot 0, the wrap bit cons_idx[3] toggles. This inverts the polarity that marks a live slot.
- R6: A live slot is malformed when its code is not 2 or 3, or when its count is 0 or above 8. Such a slot is never presented. It is consumed one cycle after it becomes visible, and err_sticky becomes 1 and stays 1 until reset.
- R7: In index modes (prod_mode = 0 or 1), the head slot is live whenever prod_idx differs from cons_idx. Bit 7 of the command byte is ignored.
- R8: With prod_mode = 3, no slot is presented or consumed.
- R9: Each completion adds one to a counter. A completion is either an accepted slot or a dropped slot. When the new count reaches irq_thresh, or on every completion when irq_thresh is 0, irq is set and the counter restarts from 0.
- R10: A pulse on irq_clr clears irq, unless a new threshold crossing happens in the same cycle. In that case the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prod_mode | input | 2 | 0/1 index modes, 2 valid-bit mode, 3 idle |
| prod_idx | input | 4 | Producer index with wrap bit, used in index modes |
| wr_en | input | 1 | Write one ring slot |
| wr_slot | input | 3 | Slot number written |
| wr_verb | input | 8 | Command byte: presence flag, code, count |
| wr_pool | input | 8 | Pool byte |
| irq_thresh | input | 4 | Completion threshold for the interrupt |
| irq_clr | input | 1 | Write-one clear of irq |
| st_ready | input | 1 | Buffer store accepts the presented slot |
| st_valid | output | 1 | A well-formed slot is presented |
| st_count | output | 4 | Buffer count of the presented slot |
| st_pool | output | 8 | Pool byte of the presented slot |
| st_per_buf | output | 1 | Each buffer carries its own pool id |
| cons_idx | output | 4 | Consumer index with wrap bit |
| err_sticky | output | 1 | A malformed slot was dropped |
| irq | output | 1 | Completion threshold interrupt |

## Verification
The assertions check the following on every cycle:
- the consumer index only ever steps by one, and it steps on every accepted handshake;
- a presented slot stays steady while the store stalls;
- the presented count stays within 1 to 8;
- the error flag never falls, and the interrupt only falls after a clear pulse;
- the idle mode never moves the index.

Some behaviours only the bench scenarios can show. One is that the expected polarity flips across two wraps, so stale slots from an earlier lap stay invisible. Others are the exact decode of count, pool and per-buffer flag, the dropping of each kind of malformed slot, and the threshold interrupt at a given completion number.

// File: rtl/vbr_pkg.sv
package vbr_pkg;

    typedef enum logic [1:0] {
        PM_IDX_UNCACHED = 2'd0,
        PM_IDX_CACHED   = 2'd1,
        PM_VALID_BIT    = 2'd2,
        PM_IDLE         = 2'd3
    } prod_mode_e;

    localparam logic [2:0] CMD_SHARED_POOL = 3'h2;
    localparam logic [2:0] CMD_PER_BUF     = 3'h3;

    typedef struct packed {
        logic [7:0] verb;
        logic [7:0] pool;
    } slot_t;

endpackage

// File: rtl/vbr_slots.sv
module vbr_slots
    import vbr_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_slot,
    input  slot_t            wr_data,
    input  logic [IDX_W-1:0] rd_slot,
    output slot_t            rd_data
);

    slot_t mem_d [DEPTH];
    slot_t mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (wr_en) begin
            mem_d[wr_slot] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) mem_q[i] <= '0;
            else        mem_q[i] <= mem_d[i];
        end
    end

    assign rd_data = mem_q[rd_slot];

endmodule

// File: rtl/vbr_decode.sv
module vbr_decode
    import vbr_pkg::*;
#(
    parameter int MAX_BUFS = 8
) (
    input  slot_t       head,
    output logic        well_formed,
    output logic [3:0]  count,
    output logic [7:0]  pool,
    output logic        per_buf
);

    logic [2:0] code;

    always_comb begin
        code        = head.verb[6:4];
        count       = head.verb[3:0];
        pool        = head.pool;
        per_buf     = (code == CMD_PER_BUF);
        well_formed = ((code == CMD_SHARED_POOL) || (code == CMD_PER_BUF))
                      && (count != 4'd0)
                      && (int'(count) <= MAX_BUFS);
    end

endmodule

// File: rtl/vbr_irq.sv
module vbr_irq #(
    parameter int THR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             done,
    input  logic [THR_W-1:0] thresh,
    input  logic             clr,
    output logic             irq
);

    typedef struct packed {
        logic [THR_W-1:0] cnt;
        logic             irq;
    } irq_state_t;

    irq_state_t s_d, s_q;
    logic [THR_W-1:0] next_cnt;

    always_comb begin
        s_d      = s_q;
        next_cnt = s_q.cnt + 1'b1;
        if (clr) s_d.irq = 1'b0;
        if (done) begin
            if ((thresh == '0) || (next_cnt >= thresh)) begin
                s_d.irq = 1'b1;
                s_d.cnt = '0;
            end else begin
                s_d.cnt = next_cnt;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign irq = s_q.irq;

endmodule

// File: rtl/vbr_ring_consumer.sv
module vbr_ring_consumer
    import vbr_pkg::*;
#(
    parameter int   DEPTH      = 8,
    parameter int   MAX_BUFS   = 8,
    parameter int   THR_W      = 4,
    parameter logic RESET_WRAP = 1'b1,
    localparam int  IDX_W      = $clog2(DEPTH),
    localparam int  PTR_W      = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       prod_mode,
    input  logic [PTR_W-1:0] prod_idx,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_slot,
    input  logic [7:0]       wr_verb,
    input  logic [7:0]       wr_pool,
    input  logic [THR_W-1:0] irq_thresh,
    input  logic             irq_clr,
    input  logic             st_ready,
    output logic             st_valid,
    output logic [3:0]       st_count,
    output logic [7:0]       st_pool,
    output logic             st_per_buf,
    output logic [PTR_W-1:0] cons_idx,
    output logic             err_sticky,
    output logic             irq
);

    typedef struct packed {
        logic [PTR_W-1:0] ci;
        logic             err;
    } cons_state_t;

    cons_state_t s_d, s_q;
    slot_t       head;
    slot_t       wr_data;
    logic        well_formed;
    logic        live;
    logic        drop;
    logic        done;
    prod_mode_e  mode;

    assign wr_data = '{verb: wr_verb, pool: wr_pool};
    assign mode    = prod_mode_e'(prod_mode);

    vbr_slots #(.DEPTH(DEPTH)) i_slots (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_slot (wr_slot),
        .wr_data (wr_data),
        .rd_slot (s_q.ci[IDX_W-1:0]),
        .rd_data (head)
    );

    vbr_decode #(.MAX_BUFS(MAX_BUFS)) i_decode (
        .head        (head),
        .well_formed (well_formed),
        .count       (st_count),
        .pool        (st_pool),
        .per_buf     (st_per_buf)
    );

    always_comb begin
        unique case (mode)
            PM_VALID_BIT:    live = (head.verb[7] == s_q.ci[IDX_W]);
            PM_IDX_UNCACHED,
            PM_IDX_CACHED:   live = (prod_idx != s_q.ci);
            default:         live = 1'b0;
        endcase
        st_valid = live && well_formed;
        drop     = live && !well_formed;
        done     = (st_valid && st_ready) || drop;

        s_d = s_q;
        if (done)  s_d.ci  = s_q.ci + 1'b1;
        if (drop)  s_d.err = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.ci  <= {RESET_WRAP, {IDX_W{1'b0}}};
            s_q.err <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    vbr_irq #(.THR_W(THR_W)) i_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .done   (done),
        .thresh (irq_thresh),
        .clr    (irq_clr),
        .irq    (irq)
    );

    assign cons_idx   = s_q.ci;
    assign err_sticky = s_q.err;

endmodule

// File: rtl/vbr_ring_checker.sv
module vbr_ring_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] prod_mode,
    input logic       st_valid,
    input logic       st_ready,
    input logic [3:0] st_count,
    input logic [7:0] st_pool,
    input logic [3:0] cons_idx,
    input logic       err_sticky,
    input logic       irq,
    input logic       irq_clr
);

    assert_accept_steps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_ready) |=> (cons_idx == $past(cons_idx) + 4'd1));

    assert_index_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cons_idx != $past(cons_idx)) |-> (cons_idx == $past(cons_idx) + 4'd1));

    assert_stall_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !st_ready) |=> (st_valid && $stable(st_count) && $stable(st_pool)));

    assert_count_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |-> (st_count >= 4'd1 && st_count <= 4'd8));

    assert_err_never_falls_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(err_sticky));

    assert_idle_mode_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (prod_mode == 2'd3) |=> $stable(cons_idx));

    assert_irq_falls_on_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(irq_clr));

endmodule

bind vbr_ring_consumer vbr_ring_checker i_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .prod_mode  (prod_mode),
    .st_valid   (st_valid),
    .st_ready   (st_ready),
    .st_count   (st_count),
    .st_pool    (st_pool),
    .cons_idx   (cons_idx),
    .err_sticky (err_sticky),
    .irq        (irq),
    .irq_clr    (irq_clr)
);

// File: tb/test_vbr_ring_consumer.sv
module test_vbr_ring_consumer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] prod_mode = 2'd2;
    logic [3:0] prod_idx = '0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_slot = '0;
    logic [7:0] wr_verb = '0;
    logic [7:0] wr_pool = '0;
    logic [3:0] irq_thresh = 4'd3;
    logic       irq_clr = 1'b0;
    logic       st_ready = 1'b0;
    logic       st_valid, st_per_buf, err_sticky, irq;
    logic [3:0] st_count, cons_idx;
    logic [7:0] st_pool;

    int total = 0;
    int bad = 0;
    logic [3:0] ci = 4'b1000;
    int cnt = 0;
    logic exp_irq = 1'b0;

    always #5 clk = ~clk;

    vbr_ring_consumer i_vbr_ring_consumer (
        .clk(clk), .rst_n(rst_n), .prod_mode(prod_mode), .prod_idx(prod_idx),
        .wr_en(wr_en), .wr_slot(wr_slot), .wr_verb(wr_verb), .wr_pool(wr_pool),
        .irq_thresh(irq_thresh), .irq_clr(irq_clr), .st_ready(st_ready),
        .st_valid(st_valid), .st_count(st_count), .st_pool(st_pool),
        .st_per_buf(st_per_buf), .cons_idx(cons_idx), .err_sticky(err_sticky),
        .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_slot(input logic [2:0] s, input logic [7:0] v, input logic [7:0] p);
        wr_en = 1'b1; wr_slot = s; wr_verb = v; wr_pool = p;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic complete();
        ci = ci + 4'd1;
        cnt++;
        if (irq_thresh == 0 || cnt >= int'(irq_thresh)) begin
            exp_irq = 1'b1;
            cnt = 0;
        end
    endtask

    task automatic check_irq();
        check("R9 irq", int'(irq), int'(exp_irq));
        if (exp_irq) begin
            irq_clr = 1'b1;
            @(negedge clk);
            irq_clr = 1'b0;
            exp_irq = 1'b0;
            check("R10 irq cleared", int'(irq), 0);
        end
    endtask

    task automatic accept();
        st_ready = 1'b1;
        @(negedge clk);
        st_ready = 1'b0;
        complete();
        check("R4 index after accept", int'(cons_idx), int'(ci));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 cons_idx", int'(cons_idx), 8);
        check("R1 st_valid", int'(st_valid), 0);
        check("R1 irq", int'(irq), 0);
        check("R1 err", int'(err_sticky), 0);
        check("R3 zero slots stale", int'(st_valid), 0);

        // valid-bit mode sweep over two and a half laps
        for (int k = 0; k < 20; k++) begin
            logic [3:0] cnt_v;
            logic [2:0] code;
            logic [7:0] pool;
            cnt_v = 4'((k % 8) + 1);
            code  = (k % 2 == 1) ? 3'h3 : 3'h2;
            pool  = 8'(k * 7 + 1);
            check("R3 R5 stale before write", int'(st_valid), 0);
            write_slot(ci[2:0], {ci[3], code, cnt_v}, pool);
            check("R2 st_valid", int'(st_valid), 1);
            check("R2 st_count", int'(st_count), int'(cnt_v));
            check("R2 st_pool", int'(st_pool), int'(pool));
            check("R2 st_per_buf", int'(st_per_buf), (code == 3'h3) ? 1 : 0);
            repeat (2) @(negedge clk);
            check("R4 hold while stalled", int'(cons_idx), int'(ci));
            check("R4 valid held", int'(st_valid), 1);
            accept();
            check_irq();
        end

        // malformed slots: bad code, zero count, count above 8
        irq_thresh = 4'd0;
        for (int b = 0; b < 3; b++) begin
            logic [7:0] v;
            v = (b == 0) ? {ci[3], 3'h5, 4'd4} :
                (b == 1) ? {ci[3], 3'h2, 4'd0} : {ci[3], 3'h3, 4'd9};
            write_slot(ci[2:0], v, 8'hAA);
            check("R6 not presented", int'(st_valid), 0);
            @(negedge clk);
            complete();
            check("R6 dropped index", int'(cons_idx), int'(ci));
            check("R6 err sticky", int'(err_sticky), 1);
            check_irq();
        end

        // idle mode consumes nothing
        prod_mode = 2'd3;
        write_slot(ci[2:0], {ci[3], 3'h2, 4'd5}, 8'h33);
        repeat (3) @(negedge clk);
        check("R8 no present", int'(st_valid), 0);
        check("R8 index frozen", int'(cons_idx), int'(ci));
        prod_mode = 2'd2;
        #1;
        check("R2 presented after mode", int'(st_valid), 1);
        @(negedge clk);
        accept();
        check_irq();

        // index mode: presence flag ignored
        prod_idx = ci;
        @(negedge clk);
        prod_mode = 2'd0;
        write_slot(ci[2:0], {~ci[3], 3'h2, 4'd2}, 8'h51);
        write_slot(3'(ci[2:0] + 3'd1), {ci[3], 3'h3, 4'd8}, 8'h52);
        check("R7 empty when equal", int'(st_valid), 0);
        prod_idx = ci + 4'd2;
        @(negedge clk);
        check("R7 first live", int'(st_valid), 1);
        check("R7 first count", int'(st_count), 2);
        accept();
        check_irq();
        check("R7 second count", int'(st_count), 8);
        check("R7 second per_buf", int'(st_per_buf), 1);
        accept();
        check_irq();
        check("R7 empty after catch-up", int'(st_valid), 0);
        check("R6 err still set", int'(err_sticky), 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule